// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of instruction bytes ahead of the instruction consumer. It watches its own fill level and the execution side's operand traffic. When there is room, it issues sequential code fetches over a 16-bit memory port. Each fetch returns a whole word, and the block keeps the one or two bytes that belong to the program stream. The consumer takes bytes one at a time, in program order, through a valid/ready handshake.

On a control transfer the flush input empties the store within one cycle. A fetch that is still in flight is marked so that its data is thrown away when it arrives. The fetch offset is reloaded from the supplied target.

Only one code fetch is outstanding at a time. The bus side grants a request with `fetch_gnt`. It answers later with a single `rdata_valid` pulse, at least one cycle after the grant. Back-pressure on the consumer side works as follows: while `byte_valid` is high and `byte_ready` is low, the head byte stays on `byte_data` unchanged and is not consumed. The block never stalls the bus response, because it only requests a fetch when space for it is guaranteed.

Top module: `pfq_top`

## Requirements
- R1: While reset is asserted, `byte_valid` is 0 and `fetch_addr` is 0000h. The store holds no bytes after reset.
- R2: `fetch_req` is high only when at least two of the six byte slots are free, no fetch is outstanding or awaiting discard, and `flush` is low.
- R3: `fetch_req` is low in every cycle where `op_pending` is high, so operand accesses win the bus.
- R4: A fetch launched at an even offset appends byte [7:0] of the returned word and then byte [15:8]. `fetch_addr` advances by 2 in the cycle after the grant.
- R5: A fetch launched at an odd offset appends only byte [15:8] of the returned word. `fetch_addr` advances by 1.
- R6: Bytes leave on `byte_data` in exactly the order they were appended, one per cycle in which `byte_valid` and `byte_ready` are both high.
- R7: A pop and a one- or two-byte append in the same cycle are both applied. The store never holds more than six bytes.
- R8: A cycle with `flush` high leaves the store empty in the next cycle and sets `fetch_addr` to `flush_target`. Data from a fetch that was outstanding at the flush is discarded. `byte_valid` is low during the flush cycle.
- R9: The fetch offset is 16 bits and wraps from FFFFh or FFFEh to 0000h.
- R10: While `byte_valid` is high and `byte_ready` is low, the next cycle still shows `byte_valid` high with the same `byte_data`, unless a flush occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_pending | input | 1 | Execution side has an operand read or write waiting |
| flush | input | 1 | Discard queued bytes and restart fetching at the target |
| flush_target | input | 16 | New fetch offset loaded on flush |
| fetch_req | output | 1 | Request for a code word fetch |
| fetch_addr | output | 16 | Offset of the next code fetch |
| fetch_gnt | input | 1 | Bus accepts the request this cycle |
| rdata_valid | input | 1 | Returned fetch word is present |
| rdata | input | 16 | Returned fetch word |
| byte_valid | output | 1 | A queued byte is offered |
| byte_data | output | 8 | Oldest queued byte |
| byte_ready | input | 1 | Consumer takes the offered byte |

## Verification
The hardest case to reach is a flush that arrives while a fetch is granted but not yet answered, together with a response that comes just after the flush. In that case the stale word must not leak into the freshly reloaded stream. The stimulus holds bus responses back for up to three cycles and flushes at random points. This lands flushes inside that window many times and also on the exact cycle of a response. Odd flush targets close to FFFFh force both the single-byte loads and the offset wrap.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  typedef logic [BYTE_W-1:0] byte_t;

  // append request toward the byte ring: count of bytes and the bytes in order
  typedef struct packed {
    logic [1:0] n;
    byte_t      b0;
    byte_t      b1;
  } wr_pkt_t;
endpackage

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  wr_pkt_t                     wr,
  input  logic                        pop,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output byte_t                       head
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  byte_t          mem [DEPTH];
  logic [IW-1:0]  rd_idx, wr_idx;
  logic [CW-1:0]  count_n;

  function automatic logic [IW-1:0] adv(input logic [IW-1:0] idx, input int step);
    int s;
    s = int'(idx) + step;
    if (s >= DEPTH) s = s - DEPTH;
    return IW'(s);
  endfunction

  assign count_n = count + CW'(wr.n) - CW'(pop);
  assign head    = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_idx <= '0;
      wr_idx <= '0;
      count  <= '0;
    end else begin
      rd_idx <= adv(rd_idx, int'(pop));
      wr_idx <= adv(wr_idx, int'(wr.n));
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush) begin
      if (wr.n != 2'd0) mem[wr_idx] <= wr.b0;
      if (wr.n == 2'd2) mem[adv(wr_idx, 1)] <= wr.b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
  import pfq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_pending,
  input  logic                        flush,
  input  logic [AW-1:0]               flush_target,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  input  logic                        fetch_gnt,
  input  logic                        rdata_valid,
  input  logic [WORD_W-1:0]           rdata,
  output logic                        fetch_req,
  output logic [AW-1:0]               fetch_addr,
  output wr_pkt_t                     wr
);
  localparam int CW        = $clog2(DEPTH+1);
  localparam int MAX_START = DEPTH - LANES;

  logic          busy, stale, odd_q;
  logic          launch, accept, space_ok;
  byte_t         lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = rdata[g*BYTE_W +: BYTE_W];
  end

  assign space_ok  = count <= CW'(MAX_START);
  assign fetch_req = !busy && !stale && !op_pending && !flush && space_ok;
  assign launch    = fetch_req && fetch_gnt;
  assign accept    = rdata_valid && busy && !flush;

  always_comb begin
    wr.n  = accept ? (odd_q ? 2'd1 : 2'd2) : 2'd0;
    wr.b0 = odd_q ? lane[LANES-1] : lane[0];
    wr.b1 = lane[LANES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_addr <= '0;
      busy       <= 1'b0;
      stale      <= 1'b0;
      odd_q      <= 1'b0;
    end else if (flush) begin
      fetch_addr <= flush_target;
      busy       <= 1'b0;
      stale      <= (busy || stale) && !rdata_valid;
    end else begin
      if (rdata_valid) begin
        busy  <= 1'b0;
        stale <= 1'b0;
      end
      if (launch) begin
        busy       <= 1'b1;
        odd_q      <= fetch_addr[0];
        fetch_addr <= fetch_addr + (fetch_addr[0] ? AW'(1) : AW'(2));
      end
    end
  end

  // R3
  op_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_pending |-> !fetch_req);

  // R2
  room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> count <= CW'(MAX_START));

  // R5
  odd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_gnt && fetch_addr[0]) |=> fetch_addr == $past(fetch_addr) + AW'(1));

  // R4
  even_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_gnt && !fetch_addr[0]) |=> fetch_addr == $past(fetch_addr) + AW'(2));
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_pending,
  input  logic              flush,
  input  logic [AW-1:0]     flush_target,
  output logic              fetch_req,
  output logic [AW-1:0]     fetch_addr,
  input  logic              fetch_gnt,
  input  logic              rdata_valid,
  input  logic [15:0]       rdata,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  input  logic              byte_ready
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] count;
  wr_pkt_t       wr;
  logic          pop;
  byte_t         head;

  assign byte_valid = (count != '0) && !flush;
  assign pop        = byte_valid && byte_ready;
  assign byte_data  = head;

  pfq_fetch_ctl #(.AW(AW), .DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rst_n(rst_n), .op_pending(op_pending), .flush(flush),
    .flush_target(flush_target), .count(count), .fetch_gnt(fetch_gnt),
    .rdata_valid(rdata_valid), .rdata(rdata), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .wr(wr)
  );

  pfq_byte_ring #(.DEPTH(DEPTH)) ring_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr(wr), .pop(pop),
    .count(count), .head(head)
  );

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (flush || (byte_valid && $stable(byte_data))));
endmodule

// File: tb/pfq_top_tb_top.sv
`timescale 1ns/1ps
module pfq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_pending = 1'b0, flush = 1'b0, fetch_gnt = 1'b0;
  logic        rdata_valid = 1'b0, byte_ready = 1'b0;
  logic [15:0] flush_target = '0, rdata = '0;
  logic        fetch_req, byte_valid;
  logic [15:0] fetch_addr;
  logic [7:0]  byte_data;

  always #2 clk = ~clk;

  pfq_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_pending(op_pending), .flush(flush),
    .flush_target(flush_target), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_gnt(fetch_gnt), .rdata_valid(rdata_valid), .rdata(rdata),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready)
  );

  int n_cmp = 0, n_bad = 0;

  // reference model state
  logic [7:0]  q[$];
  logic [15:0] m_ptr = '0;
  bit          m_busy = 0, m_stale = 0, m_odd = 0;
  // bus responder state
  int          resp_cnt = 0;
  logic [15:0] resp_addr = '0;

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit rdy, input bit op, input bit gnt, input bit fl,
                      input logic [15:0] tgt, input int dly, input string tag);
    bit rv, e_valid, e_req, pop;
    rv = (resp_cnt == 1);
    byte_ready   = rdy;
    op_pending   = op;
    fetch_gnt    = gnt;
    flush        = fl;
    flush_target = tgt;
    rdata_valid  = rv;
    rdata        = {mbyte(resp_addr | 16'h1), mbyte(resp_addr & 16'hFFFE)};
    #1;
    e_valid = (q.size() != 0) && !fl;
    e_req   = !m_busy && !m_stale && !op && !fl && (6 - q.size() >= 2);
    chk(byte_valid == e_valid, tag, "byte_valid", byte_valid, e_valid);
    if (e_valid && byte_valid)
      chk(byte_data == q[0], tag, "byte_data", byte_data, q[0]);
    chk(fetch_req == e_req, tag, "fetch_req", fetch_req, e_req);
    chk(fetch_addr == m_ptr, tag, "fetch_addr", fetch_addr, m_ptr);
    // responder
    if (rv) resp_cnt = 0;
    else if (resp_cnt > 1) resp_cnt--;
    if (fetch_req && gnt) begin
      resp_cnt  = dly;
      resp_addr = fetch_addr;
    end
    // model update for the coming edge
    pop = e_valid && rdy;
    if (fl) begin
      q.delete();
      m_stale = (m_busy || m_stale) && !rv;
      m_busy  = 0;
      m_ptr   = tgt;
    end else begin
      if (pop) void'(q.pop_front());
      if (rv) begin
        if (m_busy) begin
          if (m_odd) q.push_back(mbyte(resp_addr | 16'h1));
          else begin
            q.push_back(mbyte(resp_addr & 16'hFFFE));
            q.push_back(mbyte(resp_addr | 16'h1));
          end
        end
        m_busy = 0; m_stale = 0;
      end
      if (e_req && gnt) begin
        m_busy = 1;
        m_odd  = m_ptr[0];
        m_ptr  = m_ptr + (m_ptr[0] ? 16'd1 : 16'd2);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(byte_valid == 1'b0, "R1", "byte_valid in reset", byte_valid, 0);
    chk(fetch_addr == 16'h0, "R1", "fetch_addr in reset", fetch_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // fill from an even start with the consumer stalled
    for (int i = 0; i < 12; i++) step(0, 0, 1, 0, 16'h0, 2, "R4");
    // full: requests stay low, head byte held
    for (int i = 0; i < 8; i++) step(0, 0, i[0], 0, 16'h0, 1, "R2");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 16'h0, 1, "R10");
    // operand traffic blocks prefetch while draining
    for (int i = 0; i < 10; i++) step(1, 1, 1, 0, 16'h0, 1, "R3");
    // odd target: single-byte loads
    step(1, 0, 0, 1, 16'h1235, 1, "R5");
    for (int i = 0; i < 10; i++) step(i[0], 0, 1, 0, 16'h0, 2, "R5");
    // wrap across FFFFh from odd and even
    step(1, 0, 0, 1, 16'hFFFF, 1, "R9");
    for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 16'h0, 1, "R9");
    step(0, 0, 0, 1, 16'hFFFE, 1, "R9");
    for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 16'h0, 1, "R9");
    // flush while a fetch is in flight
    step(1, 0, 1, 1, 16'h0400, 1, "R8");
    step(1, 0, 1, 0, 16'h0, 3, "R8");
    step(1, 0, 0, 1, 16'h0801, 1, "R8");
    for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 16'h0, 2, "R8");
    // random traffic: ordering and concurrent pop/append
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] t;
      int sel;
      sel = $urandom_range(0, 3);
      t = (sel == 0) ? 16'hFFFF : (sel == 1) ? 16'hFFFD : 16'($urandom);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 2) != 0, $urandom_range(0, 40) == 0, t,
           $urandom_range(1, 3), i[0] ? "R6" : "R7");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule